// File: doc/BRIEF.md
# Double-Buffered Timer Time Base

This block is the counting core of a general-purpose timer. A prescaler divides the input clock, and an up-counter runs from zero to a programmed period, then returns to zero. Both the divide setting and the period are held twice. Software writes and reads a staged copy, and the logic counts from a separate active copy. Staged values move into the active copies together on an update event. An update event happens when the counter wraps or when software requests one. Because of this, a batch of new settings takes effect in a single cycle, even though software writes them one at a time.

Software accesses the block through a simple write port and a combinational read port with four register addresses. The period has its own buffering switch. When buffering is off, a period write takes effect at once. An update-hold switch blocks all update events, so software can rewrite staged values without any of them being applied halfway. A one-clock pulse on `upd_o` marks each update event that takes effect.

Top module: `dbuf_timebase`

## Requirements
- R1: After reset, every readable register reads 0 (control, staged divide, staged period, counter), `cnt_o` is 0, `upd_o` is 0, both active settings are 0, period buffering is off and update events are allowed.
- R2: Register map at `wr_addr`/`rd_addr`:
  - Address 0 is control: bit 0 run, bit 1 update hold, bit 2 period buffering, bit 3 force-update. Bit 3 and all bits above 2 read 0.
  - Address 1 is the staged divide setting.
  - Address 2 is the staged period.
  - Address 3 reads the counter. Writes to address 3 change nothing.
- R3: While run is 1, the counter advances once every (active divide + 1) clocks. When run is 0, the counter and the prescaler hold their values.
- R4: The counter counts from 0 up to the active period and then returns to 0. If update hold is clear, that wrap is an update event. `upd_o` is 1 for exactly the one clock in which the counter first shows 0 after the event.
- R5: A write to the staged divide does not change the counting rate. The new rate applies only after the next update event.
- R6: With period buffering off, a period write becomes the active period on the same clock edge. If the counter has not reached the new value, it wraps at the new value in the current cycle. If it is already at or above the new value, it wraps on its next step.
- R7: With period buffering on, a period write has no effect on the current cycle. The counter wraps at the old active period, and the new value becomes active at that update.
- R8: Writing control with bit 3 set (while hold is clear before the write) is an update event. It loads both active settings, clears the counter and the prescaler count, and pulses `upd_o`. This works whether or not the timer is running.
- R9: While the hold bit is set, no update event occurs. `upd_o` stays 0, the active divide is not reloaded, force requests are ignored, and the counter still wraps to 0 at the active period.
- R10: Register writes take effect while run is 0, and they do not move the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 2 | Register address for the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Register address for the read |
| rd_data | output | DATA_W | Read data for `rd_addr`, combinational |
| cnt_o | output | CNT_W | Current counter value |
| upd_o | output | 1 | One-clock pulse after each update event that takes effect |

## Verification
The hardest cases to reach are a period change that lands while the counter is mid-cycle: once below the current count and once above it. Each must arrive on an exact clock with a known prescaler phase. The stimulus first forces an update to zero the prescaler and counter. With a divide of one, every counter value can then be predicted from the clock count alone. The bench waits for a chosen count and issues the period write on that clock, then predicts each later sample arithmetically. A sweep over small divide and period pairs checks every counter value and every update pulse across two full periods. Separate phases hold updates while the staged values change, and confirm that the old rate survives several wraps.

// File: rtl/tbase_pkg.sv
// Shared definitions for the double-buffered time base: register selects,
// control bit positions and the stored control word.
package tbase_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_DIV  = 2'd1,
        REG_PER  = 2'd2,
        REG_CNT  = 2'd3
    } reg_sel_e;

    localparam int CB_RUN   = 0;
    localparam int CB_HOLD  = 1;
    localparam int CB_PBUF  = 2;
    localparam int CB_FORCE = 3;

    typedef struct packed {
        logic pbuf;
        logic hold;
        logic run;
    } ctrl_t;

endpackage

// File: rtl/tbase_regfile.sv
// Software-visible register file: control bits, staged divide and staged
// period, with a combinational read mux. It also decodes the two write
// side effects other logic needs: a force-update request (only if the hold
// bit was clear before the write) and a direct period load (only if period
// buffering was off before the write).
// Assumes DATA_W >= DIV_W, DATA_W >= CNT_W and DATA_W > 3.
module tbase_regfile
    import tbase_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  cnt_i,
    output ctrl_t             ctrl_o,
    output logic [DIV_W-1:0]  pre_div_o,
    output logic [CNT_W-1:0]  pre_per_o,
    output logic              soft_req_o,
    output logic              per_direct_o
);
    localparam int PAD_W = DATA_W - 3;

    ctrl_t            ctrl_q;
    logic [DIV_W-1:0] pre_div_q;
    logic [CNT_W-1:0] pre_per_q;
    reg_sel_e         wsel;
    reg_sel_e         rsel;

    assign wsel = reg_sel_e'(wr_addr);
    assign rsel = reg_sel_e'(rd_addr);

    // Capture software writes into control and staged registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            pre_div_q <= '0;
            pre_per_q <= '0;
        end else if (wr_en) begin
            case (wsel)
                REG_CTRL: begin
                    ctrl_q.run  <= wr_data[CB_RUN];
                    ctrl_q.hold <= wr_data[CB_HOLD];
                    ctrl_q.pbuf <= wr_data[CB_PBUF];
                end
                REG_DIV: pre_div_q <= wr_data[DIV_W-1:0];
                REG_PER: pre_per_q <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Decode write side effects using the control state before the write.
    always_comb begin
        soft_req_o   = wr_en && (wsel == REG_CTRL) && wr_data[CB_FORCE] && !ctrl_q.hold;
        per_direct_o = wr_en && (wsel == REG_PER) && !ctrl_q.pbuf;
    end

    // Read mux; the force bit is never stored and so reads zero.
    always_comb begin
        case (rsel)
            REG_CTRL: rd_data = {{PAD_W{1'b0}}, ctrl_q.pbuf, ctrl_q.hold, ctrl_q.run};
            REG_DIV:  rd_data = DATA_W'(pre_div_q);
            REG_PER:  rd_data = DATA_W'(pre_per_q);
            default:  rd_data = DATA_W'(cnt_i);
        endcase
    end

    assign ctrl_o    = ctrl_q;
    assign pre_div_o = pre_div_q;
    assign pre_per_o = pre_per_q;

    // A write to the counter address leaves the staged registers untouched.
    assert_cnt_write_inert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wsel == REG_CNT) |=> ($stable(pre_div_q) && $stable(pre_per_q) && $stable(ctrl_q)));

endmodule

// File: rtl/tbase_shadow.sv
// Active (shadow) copies of the divide and period settings. Both copies load
// from their staged registers on an update event. The period also loads
// straight from write data when buffering is off; that direct load wins over
// an update in the same cycle because it carries the newer value.
module tbase_shadow #(
    parameter int DIV_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             per_direct_i,
    input  logic [CNT_W-1:0] per_wdata_i,
    input  logic [DIV_W-1:0] pre_div_i,
    input  logic [CNT_W-1:0] pre_per_i,
    output logic [DIV_W-1:0] act_div_o,
    output logic [CNT_W-1:0] act_per_o
);
    logic [DIV_W-1:0] act_div_q;
    logic [CNT_W-1:0] act_per_q;

    // Active divide follows the staged value only at update events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_div_q <= '0;
        else if (load_i)
            act_div_q <= pre_div_i;
    end

    // Active period: a direct write when unbuffered, otherwise update events.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_per_q <= '0;
        else if (per_direct_i)
            act_per_q <= per_wdata_i;
        else if (load_i)
            act_per_q <= pre_per_i;
    end

    assign act_div_o = act_div_q;
    assign act_per_o = act_per_q;

    assert_div_only_on_update_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_div_q) |-> $past(load_i));

    assert_per_change_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_per_q) |-> ($past(load_i) || $past(per_direct_i)));

    assert_per_direct_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        per_direct_i |=> (act_per_q == $past(per_wdata_i)));

endmodule

// File: rtl/tbase_prescaler.sv
// Clock divider for the counter. Counts input clocks from 0 to the active
// divide value while enabled, and issues one step strobe each time that
// count is reached. A clear restarts the phase at zero.
module tbase_prescaler #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] act_div_i,
    output logic             step_o
);
    logic [DIV_W-1:0] pcnt_q;
    logic             at_top;

    // Terminal phase; >= tolerates a divide that shrank under the phase.
    assign at_top = (pcnt_q >= act_div_i);
    assign step_o = run_i && at_top;

    // Advance the phase counter while running.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (clr_i)
            pcnt_q <= '0;
        else if (run_i)
            pcnt_q <= at_top ? '0 : pcnt_q + 1'b1;
    end

    assert_phase_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !clr_i) |=> $stable(pcnt_q));

    assert_phase_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (pcnt_q == '0));

endmodule

// File: rtl/tbase_counter.sv
// Main up-counter. On each step strobe it advances by one, or returns to zero
// once it has reached or passed the active period (the wrap). A clear forces
// zero immediately. It reports the wrap so the top can form an update event.
module tbase_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] act_per_i,
    output logic             wrap_o,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;

    // A wrap is a step taken at or beyond the active period.
    assign wrap_o = step_i && (cnt_q >= act_per_i);

    // Count steps, wrapping to zero at the period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr_i)
            cnt_q <= '0;
        else if (step_i)
            cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    assert_cnt_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clr_i) |=> $stable(cnt_q));

    assert_cnt_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i) |=> ((cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1)));

endmodule

// File: rtl/dbuf_timebase.sv
// Double-buffered timer time base: register file, active settings,
// prescaler and counter. An update event is a counter wrap or a software
// force request. A wrap is blocked while the hold bit is set. The force
// request is already filtered by hold in the register file. An update event
// reloads the active settings and pulses upd_o on the following clock.
// A force also clears the prescaler and the counter.
module dbuf_timebase
    import tbase_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              upd_o
);
    ctrl_t            ctrl;
    logic [DIV_W-1:0] pre_div;
    logic [CNT_W-1:0] pre_per;
    logic [DIV_W-1:0] act_div;
    logic [CNT_W-1:0] act_per;
    logic             soft_req;
    logic             per_direct;
    logic             step;
    logic             wrap;
    logic             upd_ev;
    logic             upd_q;

    tbase_regfile #(.DIV_W(DIV_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .rd_addr      (rd_addr),
        .rd_data      (rd_data),
        .cnt_i        (cnt_o),
        .ctrl_o       (ctrl),
        .pre_div_o    (pre_div),
        .pre_per_o    (pre_per),
        .soft_req_o   (soft_req),
        .per_direct_o (per_direct)
    );

    // Update event: an allowed wrap, or a force request.
    assign upd_ev = soft_req || (wrap && !ctrl.hold);

    tbase_shadow #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_shadow (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (upd_ev),
        .per_direct_i (per_direct),
        .per_wdata_i  (wr_data[CNT_W-1:0]),
        .pre_div_i    (pre_div),
        .pre_per_i    (pre_per),
        .act_div_o    (act_div),
        .act_per_o    (act_per)
    );

    tbase_prescaler #(.DIV_W(DIV_W)) u_psc (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .clr_i     (soft_req),
        .act_div_i (act_div),
        .step_o    (step)
    );

    tbase_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .clr_i     (soft_req),
        .act_per_i (act_per),
        .wrap_o    (wrap),
        .cnt_o     (cnt_o)
    );

    // Register the update event into a one-clock flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_q <= 1'b0;
        else
            upd_q <= upd_ev;
    end

    assign upd_o = upd_q;

    assert_flag_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (cnt_o == '0));

    assert_hold_blocks_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl.hold) |-> !upd_o);

    assert_force_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        soft_req |=> (upd_o && cnt_o == '0));

endmodule

// File: tb/sim_dbuf_timebase.sv
// Self-checking bench: reset state, an arithmetic sweep over small divide and
// period pairs, then directed phases for buffering, hold and stopped writes.
module sim_dbuf_timebase;
    localparam int DW = 16;
    localparam logic [DW-1:0] C_RUN = 16'd1, C_HOLD = 16'd2, C_PBUF = 16'd4, C_FORCE = 16'd8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] cnt_o;
    logic          upd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dbuf_timebase #(.DIV_W(16), .CNT_W(16), .DATA_W(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_o(cnt_o), .upd_o(upd_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic see(input string req, input int c, input bit u);
        chk(req, "cnt", 32'(cnt_o), 32'(c));
        chk(req, "upd", 32'(upd_o), 32'(u));
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        logic [DW-1:0] v;
        int exp_c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk("R1", "reg readback", 32'(v), 0);
        end
        see("R1", 0, 0);

        // R3 R4: sweep divide and period, model counter arithmetically
        for (int d = 0; d < 4; d++) begin
            for (int p = 0; p < 6; p++) begin
                wr(2'd0, 16'd0);
                wr(2'd1, 16'(d));
                wr(2'd2, 16'(p));
                wr(2'd0, C_RUN | C_FORCE);
                for (int k = 0; k <= 2 * (d + 1) * (p + 1) + 2; k++) begin
                    see("R3_R4", (k / (d + 1)) % (p + 1), (k % ((d + 1) * (p + 1))) == 0);
                    step();
                end
            end
        end

        // R2: readback, force bit reads zero
        rd(2'd0, v); chk("R2", "ctrl", 32'(v), 1);
        rd(2'd1, v); chk("R2", "div", 32'(v), 3);
        rd(2'd2, v); chk("R2", "per", 32'(v), 5);

        // R6: unbuffered period write ahead of and behind the counter
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd20);
        wr(2'd0, C_RUN | C_FORCE);
        repeat (5) step();
        see("R6", 5, 0);
        wr(2'd2, 16'd10);
        see("R6", 6, 0);
        repeat (4) step();
        see("R6", 10, 0);
        step();
        see("R6", 0, 1);
        repeat (8) step();
        see("R6", 8, 0);
        wr(2'd2, 16'd3);
        see("R6", 9, 0);
        step();
        see("R6", 0, 1);

        // R7: buffered period write waits for the wrap at the old period
        wr(2'd0, C_RUN | C_PBUF);
        see("R7", 1, 0);
        wr(2'd2, 16'd6);
        see("R7", 2, 0);
        step(); see("R7", 3, 0);
        step(); see("R7", 0, 1);
        for (int i = 1; i <= 6; i++) begin
            step(); see("R7", i, 0);
        end
        step(); see("R7", 0, 1);
        rd(2'd2, v); chk("R7", "staged per", 32'(v), 6);

        // R5: new divide only after the next update
        step(); see("R5", 1, 0);
        wr(2'd1, 16'd2);
        see("R5", 2, 0);
        for (int i = 3; i <= 6; i++) begin
            step(); see("R5", i, 0);
        end
        step(); see("R5", 0, 1);
        step(); see("R5", 0, 0);
        step(); see("R5", 0, 0);
        step(); see("R5", 1, 0);

        // R9: hold blocks updates, reloads and forces; counter still wraps
        wr(2'd0, 16'd0);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd4);
        wr(2'd0, C_RUN | C_FORCE);
        see("R8", 0, 1);
        wr(2'd0, C_RUN | C_HOLD);
        exp_c = 1; see("R9", exp_c, 0);
        wr(2'd1, 16'd1);
        exp_c = 2; see("R9", exp_c, 0);
        for (int i = 0; i < 8; i++) begin
            step();
            exp_c = (exp_c == 4) ? 0 : exp_c + 1;
            see("R9", exp_c, 0);
        end
        wr(2'd0, C_RUN | C_HOLD | C_FORCE);
        exp_c = (exp_c == 4) ? 0 : exp_c + 1;
        see("R9 force ignored", exp_c, 0);
        for (int i = 0; i < 3; i++) begin
            step();
            exp_c = (exp_c == 4) ? 0 : exp_c + 1;
            see("R9 rate kept", exp_c, 0);
        end
        wr(2'd0, C_RUN);
        exp_c = (exp_c == 4) ? 0 : exp_c + 1;
        see("R9", exp_c, 0);

        // R8: force loads the new divide and clears the count
        wr(2'd0, C_RUN | C_FORCE);
        see("R8", 0, 1);
        step(); see("R8", 0, 0);
        step(); see("R8", 1, 0);
        step(); see("R8", 1, 0);
        step(); see("R8", 2, 0);

        // R10: writes while stopped; counter address writes ignored (R2)
        wr(2'd0, 16'd0);
        exp_c = int'(cnt_o);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd7);
        wr(2'd3, 16'd99);
        repeat (4) step();
        see("R10", exp_c, 0);
        rd(2'd1, v); chk("R10", "div", 32'(v), 5);
        rd(2'd2, v); chk("R10", "per", 32'(v), 7);
        rd(2'd3, v); chk("R2", "cnt reg", 32'(v), 32'(exp_c));

        // R8: force while stopped; force bit reads zero
        wr(2'd0, C_FORCE);
        see("R8 stopped", 0, 1);
        rd(2'd0, v); chk("R8", "ctrl", 32'(v), 0);
        step(); see("R8 stopped", 0, 0);

        done = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule